// File: doc/BRIEF.md
# Serial 010 Detector with Permanent 100 Lockout

This block watches a one-bit serial stream, taking one bit on every rising clock edge. It raises a one-bit flag whenever the bits taken so far end in the pattern 0, 1, 0. Matches may overlap, so the stream 0 1 0 1 0 produces two hits.

The detector has a lockout. As soon as the pattern 1, 0, 0 has appeared anywhere in the stream since the last reset, the block stops reporting matches. The flag then stays low until a synchronous reset. The block is a minimized Moore machine with seven states. States are shared wherever two histories carry the same meaning. The flag is held in a flop, so it changes only at clock edges and depends only on the state.

The block is meant for control paths that must accept a marker pattern until a forbidden pattern disqualifies the stream. The stream is then abandoned until software or a parent controller resets the detector.

Top module: `seq_guard_detector`

## Requirements
- R1: A clock edge with `rst` high puts the machine in its initial state, clears the bit history and drives `hit` to 0 after that edge. Bits presented while `rst` is high are ignored.
- R2: `hit` is 1 in the cycle after an edge exactly when the bits taken since reset end in 0,1,0 (oldest first) and 1,0,0 has not occurred in them. At all other times `hit` is 0.
- R3: Matches overlap. After a hit, an input of 1 followed by 0 produces another hit, so the stream 0,1,0,1,0 gives `hit` = 0,0,1,0,1.
- R4: After 1,0,0 has been taken, `hit` stays 0 for every later input until the next reset.
- R5: A 0 taken right after a hit completes 1,0,0 and locks the detector. For example, 0,1,0,0,1,0 gives `hit` = 0,0,1,0,0,0.
- R6: Streams of only zeros or only ones never assert `hit`. A history shorter than three bits since reset never asserts `hit`.
- R7: The stream 0,0,1,0,1,0,1,0,0,1,0 gives `hit` = 0,0,0,1,0,1,0,1,0,0,0. The stream 1,1,0,1,1,0,1,0,0,1,0 gives `hit` = 0,0,0,0,0,0,0,1,0,0,0.
- R8: A reset after lockout restores detection. A fresh 0,1,0 after the reset gives `hit` = 0,0,1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one serial bit is taken per edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit |
| hit | output | 1 | Registered Moore flag: history ends in 010 and no 100 has been seen |

## Verification
The two fixed eleven-bit streams pin down the exact output sequence. They separate a correct machine from one whose lockout misses the 100 that overlaps a 010 hit. Directed runs of all zeros, all ones, chained 01010 patterns and a post-hit 0 separate overlap handling from the lockout path. A reset issued while locked shows whether the lockout clears. Long random streams with resets at random points are compared against a model that keeps only the last three bits and a sticky lockout flag. These streams reach every transition, including 1 after a 10 tail and 0 after a lone 1.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE   = 3'd0,
        ST_ZEROS  = 3'd1,
        ST_TAIL01 = 3'd2,
        ST_HIT    = 3'd3,
        ST_ONES   = 3'd4,
        ST_TAIL10 = 3'd5,
        ST_LOCK   = 3'd6
    } sgd_state_e;

    typedef struct packed {
        sgd_state_e state;
        logic       flag;
    } sgd_reg_t;

    function automatic sgd_state_e sgd_step(input sgd_state_e cur, input logic bit_in);
        sgd_state_e nxt;
        unique case (cur)
            ST_IDLE:   nxt = bit_in ? ST_ONES   : ST_ZEROS;
            ST_ZEROS:  nxt = bit_in ? ST_TAIL01 : ST_ZEROS;
            ST_TAIL01: nxt = bit_in ? ST_ONES   : ST_HIT;
            ST_HIT:    nxt = bit_in ? ST_TAIL01 : ST_LOCK;
            ST_ONES:   nxt = bit_in ? ST_ONES   : ST_TAIL10;
            ST_TAIL10: nxt = bit_in ? ST_TAIL01 : ST_LOCK;
            ST_LOCK:   nxt = ST_LOCK;
            default:   nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction

    function automatic logic sgd_flag_of(input sgd_state_e st);
        return (st == ST_HIT);
    endfunction

endpackage

// File: rtl/sgd_next_state.sv
module sgd_next_state
    import sgd_pkg::*;
(
    input  sgd_reg_t cur,
    input  logic     rst,
    input  logic     din,
    output sgd_reg_t nxt
);
    sgd_state_e stepped;

    always_comb begin
        stepped = sgd_step(cur.state, din);
        if (rst) begin
            nxt.state = ST_IDLE;
            nxt.flag  = 1'b0;
        end else begin
            nxt.state = stepped;
            nxt.flag  = sgd_flag_of(stepped);
        end
    end
endmodule

// File: rtl/sgd_state_reg.sv
module sgd_state_reg
    import sgd_pkg::*;
(
    input  logic     clk,
    input  sgd_reg_t d,
    output sgd_reg_t q
);
    always_ff @(posedge clk) begin
        q <= d;
    end
endmodule

// File: rtl/seq_guard_detector.sv
module seq_guard_detector
    import sgd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic hit
);
    sgd_reg_t cur_q;
    sgd_reg_t nxt_d;

    sgd_next_state u_next (
        .cur (cur_q),
        .rst (rst),
        .din (din),
        .nxt (nxt_d)
    );

    sgd_state_reg u_reg (
        .clk (clk),
        .d   (nxt_d),
        .q   (cur_q)
    );

    assign hit = cur_q.flag;
endmodule

// File: rtl/sgd_checker.sv
module sgd_checker
    import sgd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       din,
    input logic       hit,
    input sgd_state_e state
);
    logic rst_q = 1'b0;

    always @(posedge clk) begin
        rst_q <= rst;
        if (rst_q) begin
            assert_reset_clears_R1: assert (!hit && state == ST_IDLE)
                else $error("R1 violated after reset");
        end
    end

    // R2: a hit always follows a 0 input from the tail-01 state
    assert_hit_after_tail_R2: assert property (@(posedge clk) disable iff (rst)
        hit |-> ($past(state) == ST_TAIL01 && !$past(din) && !$past(rst)));

    // R3: a 1 after a hit keeps the 01 prefix alive
    assert_overlap_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HIT && din) |=> (state == ST_TAIL01 && !hit));

    // R4: lockout is permanent and silent
    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCK) |=> (state == ST_LOCK && !hit));

    // R5: a 0 after a hit forms 100 and locks
    assert_hit_then_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HIT && !din) |=> (state == ST_LOCK));

    // R6: uniform streams keep the flag low
    assert_runs_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_ZEROS && !din) || (state == ST_ONES && din)) |=> !hit);
endmodule

bind seq_guard_detector sgd_checker u_sgd_checker (
    .clk   (clk),
    .rst   (rst),
    .din   (din),
    .hit   (hit),
    .state (cur_q.state)
);

// File: tb/seq_guard_detector_test.sv
module seq_guard_detector_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic hit;

    int checks = 0;
    int errors = 0;

    logic [2:0] hist;
    int         nbits;
    logic       seen100;

    seq_guard_detector uut (
        .clk (clk),
        .rst (rst),
        .din (din),
        .hit (hit)
    );

    always #5 clk = ~clk;

    function automatic logic model_hit(input logic [2:0] h, input int n, input logic s);
        return (n >= 3) && (h == 3'b010) && !s;
    endfunction

    task automatic check(input logic exp, input string tag);
        checks++;
        if (hit !== exp) begin
            errors++;
            $display("FAIL %s: hit=%b expected=%b", tag, hit, exp);
        end
    endtask

    task automatic do_reset(input logic junk);
        rst = 1'b1;
        din = junk;
        @(posedge clk);
        hist = 3'b000; nbits = 0; seen100 = 1'b0;
        @(negedge clk);
        check(1'b0, "R1 reset");
        rst = 1'b0;
    endtask

    task automatic step(input logic b, input string tag);
        din = b;
        @(posedge clk);
        hist = {hist[1:0], b};
        if (nbits < 3) nbits++;
        if (nbits >= 3 && hist == 3'b100) seen100 = 1'b1;
        @(negedge clk);
        check(model_hit(hist, nbits, seen100), tag);
    endtask

    task automatic step_fixed(input logic b, input logic exp, input string tag);
        step(b, tag);
        check(exp, tag);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [10:0] sa, za, sb, zb;
        int unused_seed;
        hist = 3'b000; nbits = 0; seen100 = 1'b0;
        @(negedge clk);
        do_reset(1'b1);

        // R7 stream A, oldest bit at index 10
        sa = 11'b00101010010; za = 11'b00010101000;
        for (int i = 10; i >= 0; i--) step_fixed(sa[i], za[i], "R7 stream A");
        do_reset(1'b0);
        sb = 11'b11011010010; zb = 11'b00000001000;
        for (int i = 10; i >= 0; i--) step_fixed(sb[i], zb[i], "R7 stream B");

        // R8: lockout cleared by reset
        do_reset(1'b1);
        step_fixed(1'b0, 1'b0, "R8 fresh");
        step_fixed(1'b1, 1'b0, "R8 fresh");
        step_fixed(1'b0, 1'b1, "R8 fresh hit");

        // R3 overlap
        do_reset(1'b0);
        step_fixed(1'b0, 1'b0, "R3");
        step_fixed(1'b1, 1'b0, "R3");
        step_fixed(1'b0, 1'b1, "R3 first");
        step_fixed(1'b1, 1'b0, "R3");
        step_fixed(1'b0, 1'b1, "R3 second");
        // R5 then R4
        step_fixed(1'b0, 1'b0, "R5 lock");
        step_fixed(1'b1, 1'b0, "R4");
        step_fixed(1'b0, 1'b0, "R4 010 ignored");
        for (int i = 0; i < 6; i++) step_fixed(i[0], 1'b0, "R4 locked");

        // R6 uniform runs and short history
        do_reset(1'b0);
        for (int i = 0; i < 8; i++) step_fixed(1'b0, 1'b0, "R6 zeros");
        do_reset(1'b0);
        for (int i = 0; i < 8; i++) step_fixed(1'b1, 1'b0, "R6 ones");
        do_reset(1'b0);
        step_fixed(1'b1, 1'b0, "R6 short");
        step_fixed(1'b0, 1'b0, "R6 short");
        // R1: bits before reset dropped, 0,1 then reset then 0
        do_reset(1'b0);
        step_fixed(1'b0, 1'b0, "R1");
        step_fixed(1'b1, 1'b0, "R1");
        do_reset(1'b0);
        step_fixed(1'b0, 1'b0, "R1 history cleared");

        // R2 random streams against the model
        unused_seed = $urandom(32'h0000_5eed);
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 19) == 0) do_reset($urandom_range(0, 1) == 1);
            else step($urandom_range(0, 1) == 1, "R2 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule